// File: doc/BRIEF.md
# Relocatable Memory Map Address Decoder

This block turns a 16-bit CPU address into exactly one select line. The possible targets are on-chip RAM, the control register block, ROM, EEPROM and the external bus. RAM and the register block are not fixed in the map. An 8-bit placement register inside the register block holds one 4-bit page number for each of them. Each can therefore start at the base of any 4-Kbyte page. ROM and EEPROM sit at fixed ranges. Each has a configuration enable that can hand its range back to the external bus. In single-chip mode, ROM stays enabled whatever its enable input says.

The placement register has a protected write window in normal modes. It takes a single write, and only while fewer than 64 bus-cycle strobes have elapsed since reset. After that it only reads back. In the special modes (bootstrap and test) it can be rewritten at any time. The selects and the read-back data are combinational from the address and the current placement. A write takes effect at the clock edge that ends its bus cycle.

Top module: `memmap_decoder`

## Requirements
- R1: After reset the placement register reads 0x01, which puts RAM at page 0x0 and the register block at page 0x1.
- R2: Address A selects RAM when A[15:12] equals placement bits 7:4 and A[11:9] is zero, giving 512 bytes from the page base.
- R3: Address A selects the register block when A[15:12] equals placement bits 3:0 and A[11:6] is zero, giving 64 bytes. A read at block offset 0x3D returns the placement register. Every other address returns 0x00 on the read-back port.
- R4: Regions are ranked register block, then RAM, then EEPROM, then ROM. An address claimed by none of them goes to the external bus. Exactly one select is high for every address.
- R5: In normal modes (mode 2'b00 single-chip, 2'b01 expanded), a write is a cycle with bus strobe and write high at block offset 0x3D. It is accepted only while fewer than 64 bus strobes have completed since reset, and only if no earlier write was accepted. Later writes leave the register unchanged.
- R6: In special modes (mode bit 1 set: 2'b10 bootstrap, 2'b11 test), every write to offset 0x3D is accepted, at any time and any number of times.
- R7: ROM covers 0xE000–0xFFFF. With rom_en_i low and the mode not single-chip, that range is not selected as ROM.
- R8: In single-chip mode (2'b00), ROM covers its range even when rom_en_i is low.
- R9: EEPROM covers 0xB600–0xB7FF. With ee_en_i low, that range is not selected as EEPROM.
- R10: The window counter advances only on cycles with bus_cyc_i high. Clock cycles without a strobe do not shorten the write window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 2 | Operating mode: 00 single-chip, 01 expanded, 10 bootstrap, 11 test |
| addr_i | input | 16 | CPU address |
| bus_cyc_i | input | 1 | One-cycle strobe marking a completed bus cycle |
| wr_i | input | 1 | Write strobe for the current bus cycle |
| wdata_i | input | 8 | Write data |
| rom_en_i | input | 1 | ROM present in the map |
| ee_en_i | input | 1 | EEPROM present in the map |
| sel_reg_o | output | 1 | Register block select |
| sel_ram_o | output | 1 | RAM select |
| sel_ee_o | output | 1 | EEPROM select |
| sel_rom_o | output | 1 | ROM select |
| sel_ext_o | output | 1 | External bus select |
| rdata_o | output | 8 | Placement register read-back at offset 0x3D, else zero |

## Verification
The decoder is swept over all 65,536 addresses under six placements and enable combinations:
- the reset placement;
- RAM and the register block on separate pages;
- both on the ROM page (0xEE), which separates register-over-RAM and RAM-over-ROM ranking;
- both on page zero (0x00);
- RAM in the EEPROM page (0xB1);
- single-chip mode with the ROM enable low.

Each sweep is compared against an arithmetic model of the ranges and their ranking.

The write window is probed in three ways:
- a write on the 64th strobe, after many strobe-free cycles, which exposes a counter that counts clocks or stops one strobe early;
- a write on the 65th strobe, which must be ignored;
- a second write, which must be ignored.

Repeated writes in special modes show that the lock does not apply there.

// File: rtl/memmap_pkg.sv
package memmap_pkg;

    typedef enum logic [1:0] {
        MODE_SINGLE   = 2'b00,
        MODE_EXPANDED = 2'b01,
        MODE_BOOT     = 2'b10,
        MODE_TEST     = 2'b11
    } mode_e;

    typedef struct packed {
        logic ext;
        logic rom;
        logic ee;
        logic ram;
        logic regs;
    } sel_t;

    function automatic logic is_special(input logic [1:0] mode);
        return mode[1];
    endfunction

endpackage

// File: rtl/memmap_window.sv
module memmap_window #(
    parameter int WINDOW = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bus_cyc_i,
    input  logic special_i,
    input  logic wr_hit_i,
    output logic wr_ok_o,
    output logic locked_o
);
    localparam int CNT_W = $clog2(WINDOW + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(WINDOW);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             written;
    } win_state_t;

    win_state_t st_d, st_q;
    logic       open_w;

    always_comb begin
        st_d    = st_q;
        open_w  = (st_q.cnt < CNT_MAX) && !st_q.written;
        wr_ok_o = wr_hit_i && (special_i || open_w);
        if (bus_cyc_i && (st_q.cnt < CNT_MAX)) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
        if (wr_ok_o && !special_i) begin
            st_d.written = 1'b1;
        end
        locked_o = !open_w;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/memmap_mapreg.sv
module memmap_mapreg #(
    parameter int          MAP_W     = 8,
    parameter logic [MAP_W-1:0] MAP_RESET = 8'h01
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en_i,
    input  logic [MAP_W-1:0] wdata_i,
    output logic [MAP_W-1:0] map_o
);
    typedef struct packed {
        logic [MAP_W-1:0] map;
    } map_state_t;

    map_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en_i) begin
            st_d.map = wdata_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.map <= MAP_RESET;
        end else begin
            st_q <= st_d;
        end
    end

    assign map_o = st_q.map;
endmodule

// File: rtl/memmap_page_match.sv
module memmap_page_match #(
    parameter int ADDR_W     = 16,
    parameter int PAGE_SHIFT = 12,
    parameter int SPAN_W     = 9
) (
    input  logic [ADDR_W-1:0]            addr_i,
    input  logic [ADDR_W-PAGE_SHIFT-1:0] page_i,
    output logic                         hit_o
);
    always_comb begin
        hit_o = (addr_i[ADDR_W-1:PAGE_SHIFT] == page_i)
             && (addr_i[PAGE_SHIFT-1:SPAN_W] == '0);
    end
endmodule

// File: rtl/memmap_region_dec.sv
module memmap_region_dec
    import memmap_pkg::*;
#(
    parameter int               ADDR_W     = 16,
    parameter int               NIB_W      = 4,
    parameter int               RAM_SPAN_W = 9,
    parameter int               REG_SPAN_W = 6,
    parameter logic [ADDR_W-1:0] ROM_BASE  = 16'hE000,
    parameter int               ROM_SPAN_W = 13,
    parameter logic [ADDR_W-1:0] EE_BASE   = 16'hB600,
    parameter int               EE_SPAN_W  = 9
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [NIB_W-1:0]  ram_page_i,
    input  logic [NIB_W-1:0]  reg_page_i,
    input  logic              rom_on_i,
    input  logic              ee_on_i,
    output sel_t              sel_o
);
    localparam int PAGE_SHIFT = ADDR_W - NIB_W;
    localparam int N_RELOC    = 2;
    localparam int SPAN_TAB [N_RELOC] = '{REG_SPAN_W, RAM_SPAN_W};

    logic [N_RELOC-1:0] reloc_hit;
    logic [NIB_W-1:0]   pages [N_RELOC];
    logic               rom_hit, ee_hit;

    assign pages[0] = reg_page_i;
    assign pages[1] = ram_page_i;

    for (genvar g = 0; g < N_RELOC; g++) begin : g_reloc
        memmap_page_match #(
            .ADDR_W    (ADDR_W),
            .PAGE_SHIFT(PAGE_SHIFT),
            .SPAN_W    (SPAN_TAB[g])
        ) u_match (
            .addr_i(addr_i),
            .page_i(pages[g]),
            .hit_o (reloc_hit[g])
        );
    end

    always_comb begin
        rom_hit = rom_on_i
               && (addr_i[ADDR_W-1:ROM_SPAN_W] == ROM_BASE[ADDR_W-1:ROM_SPAN_W]);
        ee_hit  = ee_on_i
               && (addr_i[ADDR_W-1:EE_SPAN_W] == EE_BASE[ADDR_W-1:EE_SPAN_W]);
        sel_o = '0;
        if (reloc_hit[0]) begin
            sel_o.regs = 1'b1;
        end else if (reloc_hit[1]) begin
            sel_o.ram = 1'b1;
        end else if (ee_hit) begin
            sel_o.ee = 1'b1;
        end else if (rom_hit) begin
            sel_o.rom = 1'b1;
        end else begin
            sel_o.ext = 1'b1;
        end
    end
endmodule

// File: rtl/memmap_decoder.sv
module memmap_decoder
    import memmap_pkg::*;
#(
    parameter int               ADDR_W     = 16,
    parameter int               MAP_W      = 8,
    parameter logic [MAP_W-1:0] MAP_RESET  = 8'h01,
    parameter int               WINDOW     = 64,
    parameter int               RAM_SPAN_W = 9,
    parameter int               REG_SPAN_W = 6,
    parameter logic [REG_SPAN_W-1:0] MAP_OFFSET = 6'h3D,
    parameter logic [ADDR_W-1:0] ROM_BASE  = 16'hE000,
    parameter int               ROM_SPAN_W = 13,
    parameter logic [ADDR_W-1:0] EE_BASE   = 16'hB600,
    parameter int               EE_SPAN_W  = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        mode_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              bus_cyc_i,
    input  logic              wr_i,
    input  logic [MAP_W-1:0]  wdata_i,
    input  logic              rom_en_i,
    input  logic              ee_en_i,
    output logic              sel_reg_o,
    output logic              sel_ram_o,
    output logic              sel_ee_o,
    output logic              sel_rom_o,
    output logic              sel_ext_o,
    output logic [MAP_W-1:0]  rdata_o
);
    localparam int NIB_W = MAP_W / 2;

    sel_t             sel;
    logic [MAP_W-1:0] map_q;
    logic             special, rom_on, at_map, wr_hit, wr_ok, win_locked;

    always_comb begin
        special = is_special(mode_i);
        rom_on  = rom_en_i || (mode_e'(mode_i) == MODE_SINGLE);
        at_map  = sel.regs && (addr_i[REG_SPAN_W-1:0] == MAP_OFFSET);
        wr_hit  = at_map && bus_cyc_i && wr_i;
        rdata_o = at_map ? map_q : '0;
    end

    memmap_region_dec #(
        .ADDR_W    (ADDR_W),
        .NIB_W     (NIB_W),
        .RAM_SPAN_W(RAM_SPAN_W),
        .REG_SPAN_W(REG_SPAN_W),
        .ROM_BASE  (ROM_BASE),
        .ROM_SPAN_W(ROM_SPAN_W),
        .EE_BASE   (EE_BASE),
        .EE_SPAN_W (EE_SPAN_W)
    ) u_dec (
        .addr_i    (addr_i),
        .ram_page_i(map_q[MAP_W-1:NIB_W]),
        .reg_page_i(map_q[NIB_W-1:0]),
        .rom_on_i  (rom_on),
        .ee_on_i   (ee_en_i),
        .sel_o     (sel)
    );

    memmap_window #(
        .WINDOW(WINDOW)
    ) u_win (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_cyc_i(bus_cyc_i),
        .special_i(special),
        .wr_hit_i (wr_hit),
        .wr_ok_o  (wr_ok),
        .locked_o (win_locked)
    );

    memmap_mapreg #(
        .MAP_W    (MAP_W),
        .MAP_RESET(MAP_RESET)
    ) u_map (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en_i(wr_ok),
        .wdata_i(wdata_i),
        .map_o  (map_q)
    );

    assign sel_reg_o = sel.regs;
    assign sel_ram_o = sel.ram;
    assign sel_ee_o  = sel.ee;
    assign sel_rom_o = sel.rom;
    assign sel_ext_o = sel.ext;
endmodule

// File: rtl/memmap_checker.sv
module memmap_checker #(
    parameter int               ADDR_W     = 16,
    parameter int               MAP_W      = 8,
    parameter logic [MAP_W-1:0] MAP_RESET  = 8'h01,
    parameter logic [ADDR_W-1:0] ROM_BASE  = 16'hE000,
    parameter int               ROM_SPAN_W = 13
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        mode_i,
    input logic [ADDR_W-1:0] addr_i,
    input logic              rom_en_i,
    input logic              ee_en_i,
    input logic              sel_reg_o,
    input logic              sel_ram_o,
    input logic              sel_ee_o,
    input logic              sel_rom_o,
    input logic              sel_ext_o,
    input logic [MAP_W-1:0]  rdata_o,
    input logic [MAP_W-1:0]  map_q,
    input logic              win_locked
);
    logic in_rom_range;
    assign in_rom_range = addr_i[ADDR_W-1:ROM_SPAN_W] == ROM_BASE[ADDR_W-1:ROM_SPAN_W];

    p_reset_map_r1: assert property (@(posedge clk)
        !rst_n |=> map_q == MAP_RESET);

    p_one_select_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({sel_reg_o, sel_ram_o, sel_ee_o, sel_rom_o, sel_ext_o}) == 1);

    p_rdata_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_reg_o |-> rdata_o == '0);

    p_locked_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (win_locked && !mode_i[1]) |=> $stable(map_q));

    p_rom_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!rom_en_i && mode_i != 2'b00) |-> !sel_rom_o);

    p_single_rom_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == 2'b00 && in_rom_range && !sel_reg_o && !sel_ram_o && !sel_ee_o)
        |-> sel_rom_o);

    p_ee_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !ee_en_i |-> !sel_ee_o);
endmodule

bind memmap_decoder memmap_checker #(
    .ADDR_W    (ADDR_W),
    .MAP_W     (MAP_W),
    .MAP_RESET (MAP_RESET),
    .ROM_BASE  (ROM_BASE),
    .ROM_SPAN_W(ROM_SPAN_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_i    (mode_i),
    .addr_i    (addr_i),
    .rom_en_i  (rom_en_i),
    .ee_en_i   (ee_en_i),
    .sel_reg_o (sel_reg_o),
    .sel_ram_o (sel_ram_o),
    .sel_ee_o  (sel_ee_o),
    .sel_rom_o (sel_rom_o),
    .sel_ext_o (sel_ext_o),
    .rdata_o   (rdata_o),
    .map_q     (map_q),
    .win_locked(win_locked)
);

// File: tb/memmap_decoder_bench.sv
module memmap_decoder_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  mode = 2'b01;
    logic [15:0] addr = 16'h8000;
    logic        bus_cyc = 1'b0;
    logic        wr = 1'b0;
    logic [7:0]  wdata = 8'h00;
    logic        rom_en = 1'b1;
    logic        ee_en = 1'b1;
    logic        s_reg, s_ram, s_ee, s_rom, s_ext;
    logic [7:0]  rdata;

    int n_vec = 0;
    int n_bad = 0;
    int cycles = 0;
    bit done = 0;

    logic [7:0] m_map;
    int         m_cnt;
    bit         m_written;

    always #10 clk = ~clk;

    memmap_decoder u_memmap_decoder (
        .clk(clk), .rst_n(rst_n), .mode_i(mode), .addr_i(addr),
        .bus_cyc_i(bus_cyc), .wr_i(wr), .wdata_i(wdata),
        .rom_en_i(rom_en), .ee_en_i(ee_en),
        .sel_reg_o(s_reg), .sel_ram_o(s_ram), .sel_ee_o(s_ee),
        .sel_rom_o(s_rom), .sel_ext_o(s_ext), .rdata_o(rdata)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            n_bad++;
            $display("FAIL watchdog: run hung, actual cycles=%0d expected done", cycles);
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    task automatic do_reset(input logic [1:0] md);
        @(negedge clk);
        rst_n = 1'b0; mode = md; bus_cyc = 0; wr = 0;
        m_map = 8'h01; m_cnt = 0; m_written = 0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic strobe(input bit is_wr, input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; bus_cyc = 1; wr = is_wr; wdata = d;
        @(posedge clk);
        if (is_wr && (mode[1] || (m_cnt < 64 && !m_written))) begin
            m_map = d;
            if (!mode[1]) m_written = 1;
        end
        if (m_cnt < 64) m_cnt++;
        @(negedge clk);
        bus_cyc = 0; wr = 0; addr = 16'h8000;
    endtask

    task automatic write_map(input logic [7:0] d);
        strobe(1'b1, {m_map[3:0], 12'h03D}, d);
    endtask

    task automatic check_read(input string tag, input logic [7:0] exp);
        @(negedge clk);
        addr = {m_map[3:0], 12'h03D};
        #1;
        n_vec++;
        if (rdata !== exp) begin
            n_bad++;
            $display("FAIL %s readback: actual=%h expected=%h", tag, rdata, exp);
        end
    endtask

    task automatic sweep(input string tag);
        for (int i = 0; i < 65536; i++) begin
            logic [15:0] a;
            logic        h_reg, h_ram, h_ee, h_rom;
            logic [4:0]  e_sel, got;
            logic [7:0]  e_rd;
            a = 16'(i);
            addr = a;
            #1;
            h_reg = (a[15:12] == m_map[3:0]) && (a[11:6] == 6'd0);
            h_ram = (a[15:12] == m_map[7:4]) && (a[11:9] == 3'd0);
            h_ee  = ee_en && (int'(a) >= 'hB600) && (int'(a) < 'hB800);
            h_rom = (rom_en || mode == 2'b00) && (int'(a) >= 'hE000);
            if (h_reg)      e_sel = 5'b00001;
            else if (h_ram) e_sel = 5'b00010;
            else if (h_ee)  e_sel = 5'b00100;
            else if (h_rom) e_sel = 5'b01000;
            else            e_sel = 5'b10000;
            e_rd = (h_reg && a[5:0] == 6'h3D) ? m_map : 8'h00;
            got = {s_ext, s_rom, s_ee, s_ram, s_reg};
            n_vec++;
            if (got !== e_sel || rdata !== e_rd) begin
                n_bad++;
                $display("FAIL %s addr=%h sel actual=%b expected=%b rdata actual=%h expected=%h",
                         tag, a, got, e_sel, rdata, e_rd);
            end
        end
        addr = 16'h8000;
    endtask

    initial begin
        // R1: reset placement
        do_reset(2'b01);
        check_read("R1", 8'h01);
        rom_en = 1; ee_en = 1;
        sweep("R1/R2/R3/R4");

        // R10 + R5: strobe-free clocks do not use the window; 64th strobe still writes
        do_reset(2'b01);
        repeat (63) strobe(1'b0, 16'h8000, 8'h00);
        repeat (100) @(negedge clk);
        write_map(8'h32);
        check_read("R10", 8'h32);
        write_map(8'h45);
        check_read("R5", 8'h32);
        sweep("R2/R3/R4/R5");

        // R5: the 65th strobe is outside the window
        do_reset(2'b01);
        repeat (64) strobe(1'b0, 16'h8000, 8'h00);
        write_map(8'h77);
        check_read("R5", 8'h01);
        rom_en = 0; ee_en = 0;
        sweep("R7/R9");

        // R6: special modes write repeatedly, late
        do_reset(2'b10);
        repeat (100) strobe(1'b0, 16'h8000, 8'h00);
        write_map(8'hEE);
        check_read("R6", 8'hEE);
        rom_en = 0; ee_en = 1;
        sweep("R4/R6/R7");
        mode = 2'b11;
        write_map(8'h00);
        check_read("R6", 8'h00);
        rom_en = 1; ee_en = 0;
        sweep("R4/R6/R9");
        write_map(8'hB1);
        check_read("R6", 8'hB1);

        // R8: single-chip forces ROM on
        mode = 2'b00; rom_en = 0; ee_en = 1;
        sweep("R8/R9/R2");

        done = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule